// File: doc/BRIEF.md
# Oversampled Serial Receiver

This block turns an asynchronous serial line back into characters. A bit-clock enable runs at sixteen times the baud rate. The receiver waits in idle for the line to go low. It checks that the low level is still present in the middle of the start bit, and then samples every following bit once, in the middle of its sixteen bit-clock periods. The character has five to eight data bits, sent least significant bit first. An optional even or odd parity bit and one stop bit follow the data.

Each finished character goes into a one-deep receive buffer. The error flags describe what was wrong with it: a bad parity bit, a low stop bit, or a line held low for the whole frame. A data-ready flag shows that the buffer holds an unread character, and an overrun flag shows that an unread character was replaced. A single read strobe from the surrounding logic takes the character and clears every flag. The line is synchronised inside the block, so it may come straight from a pin.

Top module: `serial_rx`

## Requirements
- R1: While reset is asserted, data_ready, overrun_err, parity_err, framing_err, break_det and rx_data are all 0.
- R2: In idle, the first bit-clock tick that sees the synchronised line low starts a frame. That tick counts as cycle 1 of the start bit, and the line is sampled again on cycle 8. If the line is high at that sample, the event is dropped as a glitch: no character is delivered and the receiver returns to idle.
- R3: The data length is 5 + word_len bits (word_len 0 gives 5 bits, 3 gives 8 bits). Data bits arrive least significant bit first, each sampled 16 ticks after the previous sample. The character appears on rx_data right-justified, with the unused upper bits at 0.
- R4: With par_en = 1, a parity bit follows the data. par_odd = 0 asks for an even number of ones over the data and parity bits, and par_odd = 1 asks for an odd number. A mismatch sets parity_err together with data_ready. With par_en = 0, parity_err stays 0.
- R5: A stop bit sampled as 0 sets framing_err and still delivers the data bits. The receiver then ignores the line until it has been seen high on a tick.
- R6: If every sampled data bit, the parity bit (when enabled) and the stop bit are all 0, the frame is a break. In that case break_det = 1, rx_data = 0, data_ready = 1, and parity_err and framing_err are not set by that frame. No new start is accepted until the line has been seen high.
- R7: A finished frame sets data_ready. A one-cycle rd_strobe with no frame finishing in the same cycle clears data_ready, overrun_err, parity_err, framing_err and break_det.
- R8: If a frame finishes while data_ready is 1 and rd_strobe is 0, overrun_err is set and rx_data takes the new character. Error flags already set stay set, and the new frame's flags are added to them.
- R9: If a frame finishes in the same cycle as rd_strobe, the new character is loaded and data_ready stays 1. overrun_err stays 0, and the error flags show only the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit-clock period (16 per bit) |
| rxd | input | 1 | Serial line, idle high |
| word_len | input | LEN_W (2) | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Buffer read; clears the flags |
| rx_data | output | DATA_W (8) | Received character |
| data_ready | output | 1 | Unread character in the buffer |
| overrun_err | output | 1 | Unread character was replaced |
| parity_err | output | 1 | Parity mismatch |
| framing_err | output | 1 | Stop bit sampled low |
| break_det | output | 1 | Whole frame held low |

## Verification
Two things can happen in the same clock cycle: a frame finishing, which loads the buffer, and a read strobe, which clears it. To make them meet, the bench first starts a frame at a known bit-clock phase and records after how many cycles data_ready rises. It then leaves a character with a parity error unread. It sends another frame started at the same phase and pulses rd_strobe exactly in the load cycle. The result is judged at the ports: the new byte must be present, data_ready must still be 1, and overrun_err and the old parity_err must both be 0.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_ff
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= din;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int SAMPLE_AT  = 8,
   parameter int DATA_W     = 8,
   parameter int MIN_BITS   = 5,
   localparam int CNT_W = $clog2(OVERSAMPLE),
   localparam int LEN_W = $clog2(DATA_W - MIN_BITS + 1),
   localparam int IDX_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic [LEN_W-1:0]  word_len,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [DATA_W-1:0] data_o,
   output logic              pe_o,
   output logic              fe_o,
   output logic              bi_o
);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(SAMPLE_AT - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

   generate
      if (SAMPLE_AT < 2 || SAMPLE_AT > OVERSAMPLE) begin : g_bad_sample
         $error("SAMPLE_AT must lie in 2..OVERSAMPLE");
      end
      if ((1 << LEN_W) != DATA_W - MIN_BITS + 1) begin : g_bad_len
         $error("DATA_W - MIN_BITS + 1 must be a power of two");
      end
   endgenerate

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  bidx;
   logic [DATA_W-1:0] shreg;
   logic              par_acc, all_low, pe_q;
   logic [IDX_W-1:0]  nbits;
   logic [DATA_W-1:0] aligned;

   assign nbits   = IDX_W'(MIN_BITS) + IDX_W'(word_len);
   assign aligned = shreg >> (IDX_W'(DATA_W) - nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         all_low <= 1'b1;
         pe_q    <= 1'b0;
         done    <= 1'b0;
         data_o  <= '0;
         pe_o    <= 1'b0;
         fe_o    <= 1'b0;
         bi_o    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state <= RX_START;
                     cnt   <= CNT_W'(1);
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt     <= '0;
                     bidx    <= '0;
                     par_acc <= 1'b0;
                     all_low <= 1'b1;
                     pe_q    <= 1'b0;
                     state   <= line ? RX_IDLE : RX_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     shreg   <= {line, shreg[DATA_W-1:1]};
                     par_acc <= par_acc ^ line;
                     all_low <= all_low & ~line;
                     bidx    <= bidx + 1'b1;
                     if (bidx == nbits - 1'b1) state <= par_en ? RX_PAR : RX_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               RX_PAR: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     pe_q    <= par_acc ^ line ^ par_odd;
                     all_low <= all_low & ~line;
                     state   <= RX_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt  <= '0;
                     done <= 1'b1;
                     if (!line && all_low) begin
                        data_o <= '0;
                        bi_o   <= 1'b1;
                        fe_o   <= 1'b0;
                        pe_o   <= 1'b0;
                     end else begin
                        data_o <= aligned;
                        bi_o   <= 1'b0;
                        fe_o   <= ~line;
                        pe_o   <= pe_q;
                     end
                     state <= line ? RX_IDLE : RX_HOLD;
                  end else cnt <= cnt + 1'b1;
               end
               RX_HOLD: if (line) state <= RX_IDLE;
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R5/R6: a character is only produced by the stop-bit sample
   a_r5_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(state) == RX_STOP);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: after a low stop bit no start is accepted while the line stays low
   a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_HOLD && !line) |=> state == RX_HOLD);
endmodule

// File: rtl/rx_status.sv
module rx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data_in,
   input  logic              pe_in,
   input  logic              fe_in,
   input  logic              bi_in,
   input  logic              rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              data_ready,
   output logic              overrun_err,
   output logic              parity_err,
   output logic              framing_err,
   output logic              break_det
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         data_ready  <= 1'b0;
         overrun_err <= 1'b0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         break_det   <= 1'b0;
      end else if (done) begin
         rx_data     <= data_in;
         data_ready  <= 1'b1;
         overrun_err <= (overrun_err | data_ready) & ~rd;
         parity_err  <= pe_in | (parity_err & ~rd);
         framing_err <= fe_in | (framing_err & ~rd);
         break_det   <= bi_in | (break_det & ~rd);
      end else if (rd) begin
         data_ready  <= 1'b0;
         overrun_err <= 1'b0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         break_det   <= 1'b0;
      end
   end

   a_r7_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> $past(rd));
   a_r8_overrun_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(done && data_ready && !rd));
   a_r9_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd) |=> (data_ready && !overrun_err));
   a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(break_det) |-> rx_data == '0);
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int SAMPLE_AT   = 8,
   parameter int DATA_W      = 8,
   parameter int MIN_BITS    = 5,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W = $clog2(DATA_W - MIN_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rxd,
   input  logic [LEN_W-1:0]  word_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              data_ready,
   output logic              overrun_err,
   output logic              parity_err,
   output logic              framing_err,
   output logic              break_det
);
   logic              line_s;
   logic              f_done, f_pe, f_fe, f_bi;
   logic [DATA_W-1:0] f_data;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s));

   rx_frame_fsm #(
      .OVERSAMPLE(OVERSAMPLE), .SAMPLE_AT(SAMPLE_AT),
      .DATA_W(DATA_W), .MIN_BITS(MIN_BITS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .line(line_s),
      .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
      .done(f_done), .data_o(f_data), .pe_o(f_pe), .fe_o(f_fe), .bi_o(f_bi));

   rx_status #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .done(f_done), .data_in(f_data),
      .pe_in(f_pe), .fe_in(f_fe), .bi_in(f_bi), .rd(rd_strobe),
      .rx_data(rx_data), .data_ready(data_ready), .overrun_err(overrun_err),
      .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det));
endmodule

// File: tb/test_serial_rx.sv
module test_serial_rx;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] word_len = 2'd3;
   logic       par_en = 1'b0, par_odd = 1'b0;
   logic       mon_rd = 1'b0, man_rd = 1'b0, auto_rd = 1'b1;
   logic       rd_strobe, bit_tick;
   logic [7:0] rx_data;
   logic       data_ready, overrun_err, parity_err, framing_err, break_det;

   int tcnt = 0;
   int cyc = 0;
   always @(posedge clk) tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
   always @(posedge clk) cyc <= cyc + 1;
   assign bit_tick  = (tcnt == 0);
   assign rd_strobe = mon_rd | man_rd;

   serial_rx i_serial_rx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd),
      .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
      .rd_strobe(rd_strobe), .rx_data(rx_data), .data_ready(data_ready),
      .overrun_err(overrun_err), .parity_err(parity_err),
      .framing_err(framing_err), .break_det(break_det));

   typedef struct packed {
      logic [7:0] d;
      logic       pe, fe, bi;
   } exp_t;
   exp_t q[$];

   int n_run = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a character is waiting
   always @(negedge clk) begin
      exp_t e;
      if (mon_rd) mon_rd = 1'b0;
      else if (auto_rd && data_ready) begin
         if (q.size() == 0) chk(1'b0, "R2/R7 unexpected character", 32'(rx_data), 0);
         else begin
            e = q.pop_front();
            chk(rx_data == e.d, "R3 data", 32'(rx_data), 32'(e.d));
            chk(parity_err == e.pe, "R4 parity flag", 32'(parity_err), 32'(e.pe));
            chk(framing_err == e.fe, "R5 framing flag", 32'(framing_err), 32'(e.fe));
            chk(break_det == e.bi, "R6 break flag", 32'(break_det), 32'(e.bi));
            chk(overrun_err == 1'b0, "R8 no overrun", 32'(overrun_err), 0);
         end
         mon_rd = 1'b1;
      end
   end

   int  rise_cyc = 0;
   logic dr_q = 1'b0;
   always @(negedge clk) begin
      if (data_ready && !dr_q) rise_cyc = cyc;
      dr_q = data_ready;
   end

   task automatic bitv(input logic v);
      rxd = v;
      repeat (64) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input bit flip, input bit stopv, input bit push);
      int n;
      logic p;
      logic [7:0] m;
      exp_t e;
      n = 5 + int'(word_len);
      m = d & 8'((9'd1 << n) - 9'd1);
      p = (^m) ^ par_odd ^ flip;
      e = '{m, flip && par_en, !stopv, 1'b0};
      if (push) q.push_back(e);
      bitv(1'b0);
      for (int i = 0; i < n; i++) bitv(m[i]);
      if (par_en) bitv(p);
      bitv(stopv);
      bitv(1'b1);
   endtask

   task automatic send_break(input int bits);
      exp_t e;
      e = '{8'h00, 1'b0, 1'b0, 1'b1};
      q.push_back(e);
      rxd = 1'b0;
      repeat (bits * 64) @(negedge clk);
      bitv(1'b1);
      bitv(1'b1);
   endtask

   task automatic pulse_rd();
      man_rd = 1'b1;
      @(negedge clk);
      man_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic align();
      while (tcnt != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int t0, lat;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(data_ready == 0 && overrun_err == 0, "R1 ready/overrun in reset", {30'd0, data_ready, overrun_err}, 0);
      chk(parity_err == 0 && framing_err == 0 && break_det == 0, "R1 error flags in reset",
          {29'd0, parity_err, framing_err, break_det}, 0);
      chk(rx_data == 8'h00, "R1 buffer in reset", 32'(rx_data), 0);
      rst_n = 1'b1;
      repeat (64) @(negedge clk);

      // R3 eight bits, no parity
      send(8'hA5, 0, 1, 1);
      send(8'h3C, 0, 1, 1);
      send(8'hFF, 0, 1, 1);
      send(8'h01, 0, 1, 1);
      // R3 shorter words
      word_len = 2'd0; send(8'hF5, 0, 1, 1);
      word_len = 2'd1; send(8'h2A, 0, 1, 1);
      word_len = 2'd2; send(8'h55, 0, 1, 1);
      // R4 parity, even and odd, good and bad
      par_en = 1; par_odd = 0; send(8'h4E, 0, 1, 1); send(8'h4E, 1, 1, 1);
      word_len = 2'd3; par_odd = 1; send(8'hC3, 0, 1, 1); send(8'h80, 1, 1, 1);
      par_en = 0;

      // R2 glitch on the start bit
      rxd = 1'b0;
      repeat (12) @(negedge clk);
      rxd = 1'b1;
      repeat (128) @(negedge clk);
      chk(data_ready == 0, "R2 glitch delivers nothing", 32'(data_ready), 0);
      send(8'h96, 0, 1, 1);

      // R5 framing error, then recovery
      send(8'h6B, 0, 0, 1);
      send(8'h19, 0, 1, 1);

      // R6 break without and with parity, then recovery
      send_break(12);
      send(8'h81, 0, 1, 1);
      word_len = 2'd0; par_en = 1; par_odd = 1;
      send_break(10);
      send(8'h0A, 0, 1, 1);
      word_len = 2'd3; par_en = 0; par_odd = 0;
      chk(q.size() == 0, "R7 every character delivered", q.size(), 0);

      // R8 overrun, R7 clear on read
      auto_rd = 0;
      send(8'h11, 0, 1, 0);
      send(8'h22, 0, 0, 0);
      chk(data_ready == 1, "R8 ready kept", 32'(data_ready), 1);
      chk(overrun_err == 1, "R8 overrun set", 32'(overrun_err), 1);
      chk(rx_data == 8'h22, "R8 newest character", 32'(rx_data), 32'h22);
      chk(framing_err == 1, "R8 flags accumulate", 32'(framing_err), 1);
      pulse_rd();
      chk(data_ready == 0 && overrun_err == 0 && framing_err == 0, "R7 read clears flags",
          {29'd0, data_ready, overrun_err, framing_err}, 0);

      // R9 read in the load cycle
      par_en = 1;
      align();
      t0 = cyc;
      send(8'h5A, 0, 1, 0);
      lat = rise_cyc - t0;
      pulse_rd();
      send(8'h33, 1, 1, 0);
      chk(parity_err == 1, "R4 parity error held unread", 32'(parity_err), 1);
      align();
      t0 = cyc;
      fork
         send(8'h4C, 0, 1, 0);
         begin
            while (cyc != t0 + lat - 1) @(negedge clk);
            man_rd = 1'b1;
            @(negedge clk);
            man_rd = 1'b0;
         end
      join
      chk(data_ready == 1, "R9 ready stays set", 32'(data_ready), 1);
      chk(overrun_err == 0, "R9 no overrun", 32'(overrun_err), 0);
      chk(parity_err == 0, "R9 old parity error cleared", 32'(parity_err), 0);
      chk(rx_data == 8'h4C, "R9 new character", 32'(rx_data), 32'h4C);

      repeat (10) @(negedge clk);
      summary();
      $finish;
   end
endmodule